// File: doc/BRIEF.md
# Buffer-to-SRAM Transfer Sequencer

This block copies a run of words from an external input buffer into a local scratch SRAM. One configuration strobe programs two address generators at once. The read-side generator gets a start address, a stride and an iteration count, and requests words from the buffer with an address and an enable. The write-side generator gets its own start, stride and count, and produces the SRAM address and write strobe for each word as it arrives. For example, buffer words 0..3 can be placed at SRAM locations 3..6.

The block has two timing modes. In handshake mode the buffer answers each request with a valid beat. Each beat stores the word presented on the data bus and moves both generators forward. In fixed-latency mode the valid flag is not used. Requests go out on consecutive cycles, and each word is assumed to be on the data bus a configured number of cycles after its request. When both sides have used up their iterations, a one-cycle completion pulse goes back to the sequencer.

Top module: `buf_load_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the block goes idle. After that edge, `bufEn`, `sramWe` and `done` are low until a new configuration is accepted.
- R2: A `cfgLoad` accepted while idle makes `bufEn` high in the next cycle with `bufAddr` = `cfgRdStart`. The k-th request (k from 0) carries `cfgRdStart + k*cfgRdStep`. `cfgRdIter` requests are made in total.
- R3: With `cfgMode` = 0 (handshake), an SRAM write happens only in a cycle where `bufValid` is high and write iterations remain. In that same cycle `sramWe` is high, `sramWdata` equals `bufData`, and the j-th write uses `sramAddr` = `cfgWrStart + j*cfgWrStep`.
- R4: In handshake mode, `bufAddr` holds and `bufEn` stays high while `bufValid` is low. A high `bufValid` advances the request. `bufEn` falls in the cycle after the beat that answers the final request.
- R5: Once the write side has finished its iterations, further `bufValid` pulses cause no SRAM write.
- R6: With `cfgMode` = 1 (fixed latency), `bufValid` is ignored. Requests occupy `cfgRdIter` consecutive cycles starting the cycle after acceptance. Write j happens `cfgLat + j` cycles after the first request cycle.
- R7: `done` is high for exactly one cycle. In handshake or fixed mode it comes in the cycle after the last remaining iteration on either side completes. It comes in the cycle after acceptance when both counts are zero.
- R8: A `cfgLoad` that arrives while any iteration is outstanding is ignored, and the running transfer continues unchanged.
- R9: Read addresses wrap modulo 2^RD_AW. Write addresses wrap modulo 2^WR_AW, which is the SRAM depth.
- R10: A reset in the middle of a transfer cancels it. No further requests or writes occur, and no `done` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgLoad | input | 1 | Configuration strobe; starts both generators when idle |
| cfgMode | input | 1 | 0 = handshake, 1 = fixed latency |
| cfgRdStart | input | RD_AW | First buffer address |
| cfgRdStep | input | RD_AW | Buffer address stride |
| cfgRdIter | input | CNT_W | Number of buffer requests |
| cfgWrStart | input | WR_AW | First SRAM address |
| cfgWrStep | input | WR_AW | SRAM address stride |
| cfgWrIter | input | CNT_W | Number of SRAM writes |
| cfgLat | input | LAT_W | Fixed-mode cycles from request to data |
| bufAddr | output | RD_AW | Buffer request address |
| bufEn | output | 1 | Buffer request enable |
| bufValid | input | 1 | Buffer data valid (handshake mode) |
| bufData | input | DATA_W | Buffer data word |
| sramWe | output | 1 | SRAM write strobe |
| sramAddr | output | WR_AW | SRAM write address |
| sramWdata | output | DATA_W | SRAM write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
Requests are registered. The first request is therefore due in the cycle after acceptance, and each new request is due in the cycle after the beat that answers the previous one. The SRAM write strobe is combinational from `bufValid`, so in handshake mode a write is due in the same cycle as the beat. In fixed mode write j is due `cfgLat + j` cycles after the first request. `done` is due one cycle after the final advance. The bench changes inputs on the falling edge and compares every output shortly afterwards against a queue-based model that steps on the rising edge. Each expectation is therefore checked in exactly the cycle it belongs to.

// File: rtl/buf_load_pkg.sv
package buf_load_pkg;

  typedef enum logic {
    MODE_HANDSHAKE = 1'b0,
    MODE_FIXED     = 1'b1
  } xfer_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture start/stride into both generators
    logic rdAdv;  // step the buffer-side address
    logic wrAdv;  // step the SRAM-side address
  } step_strb_t;

endpackage

// File: rtl/buf_load_agen.sv
module buf_load_agen #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] startAddr,
  input  logic [AW-1:0] stride,
  input  logic          adv,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addrQ;
  logic [AW-1:0] strideQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ   <= '0;
      strideQ <= '0;
    end else if (load) begin
      addrQ   <= startAddr;
      strideQ <= stride;
    end else if (adv) begin
      addrQ   <= addrQ + strideQ;  // natural wrap modulo 2^AW
    end
  end

  assign addr = addrQ;

endmodule

// File: rtl/buf_load_dp.sv
module buf_load_dp
  import buf_load_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RD_AW  = 10,
  parameter int WR_AW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  step_strb_t        strb,
  input  logic [RD_AW-1:0]  cfgRdStart,
  input  logic [RD_AW-1:0]  cfgRdStep,
  input  logic [WR_AW-1:0]  cfgWrStart,
  input  logic [WR_AW-1:0]  cfgWrStep,
  input  logic [DATA_W-1:0] bufData,
  output logic [RD_AW-1:0]  bufAddr,
  output logic [WR_AW-1:0]  sramAddr,
  output logic [DATA_W-1:0] sramWdata
);

  buf_load_agen #(.AW(RD_AW)) u_rdGen (
    .clk       (clk),
    .rst       (rst),
    .load      (strb.load),
    .startAddr (cfgRdStart),
    .stride    (cfgRdStep),
    .adv       (strb.rdAdv),
    .addr      (bufAddr)
  );

  buf_load_agen #(.AW(WR_AW)) u_wrGen (
    .clk       (clk),
    .rst       (rst),
    .load      (strb.load),
    .startAddr (cfgWrStart),
    .stride    (cfgWrStep),
    .adv       (strb.wrAdv),
    .addr      (sramAddr)
  );

  // the word on the buffer bus is the word committed in a write cycle
  assign sramWdata = bufData;

endmodule

// File: rtl/buf_load_ctrl.sv
module buf_load_ctrl
  import buf_load_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgLoad,
  input  logic             cfgMode,
  input  logic [CNT_W-1:0] cfgRdIter,
  input  logic [CNT_W-1:0] cfgWrIter,
  input  logic [LAT_W-1:0] cfgLat,
  input  logic             bufValid,
  output step_strb_t       strb,
  output logic             bufEn,
  output logic             sramWe,
  output logic             done,
  output logic             modeFixed
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

  xfer_mode_e       mode;
  logic [CNT_W-1:0] rdLeft, wrLeft;
  logic [CNT_W-1:0] rdLeftNext, wrLeftNext;
  logic [LAT_W-1:0] wrWait;
  logic             doneQ;
  logic             idle, accept, rdGo, wrGo;

  assign modeFixed = (mode == MODE_FIXED);
  assign idle      = (rdLeft == '0) && (wrLeft == '0);
  assign accept    = cfgLoad && idle;

  // read side: every cycle in fixed mode, on each valid beat otherwise
  assign rdGo = (rdLeft != '0) && (modeFixed || bufValid);
  // write side: after the latency window in fixed mode, on valid otherwise
  assign wrGo = (wrLeft != '0) && (modeFixed ? (wrWait == '0) : bufValid);

  assign rdLeftNext = rdGo ? rdLeft - CNT_ONE : rdLeft;
  assign wrLeftNext = wrGo ? wrLeft - CNT_ONE : wrLeft;

  always_comb begin
    strb       = '0;
    strb.load  = accept;
    strb.rdAdv = rdGo;
    strb.wrAdv = wrGo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= MODE_HANDSHAKE;
      rdLeft <= '0;
      wrLeft <= '0;
      wrWait <= '0;
      doneQ  <= 1'b0;
    end else if (accept) begin
      mode   <= xfer_mode_e'(cfgMode);
      rdLeft <= cfgRdIter;
      wrLeft <= cfgWrIter;
      wrWait <= cfgLat;
      doneQ  <= (cfgRdIter == '0) && (cfgWrIter == '0);
    end else begin
      rdLeft <= rdLeftNext;
      wrLeft <= wrLeftNext;
      if (modeFixed && (wrWait != '0)) begin
        wrWait <= wrWait - LAT_ONE;
      end
      doneQ  <= !idle && (rdLeftNext == '0) && (wrLeftNext == '0);
    end
  end

  assign bufEn  = (rdLeft != '0);
  assign sramWe = wrGo;
  assign done   = doneQ;

endmodule

// File: rtl/buf_load_seq.sv
module buf_load_seq
  import buf_load_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RD_AW  = 10,
  parameter int WR_AW  = 8,
  parameter int CNT_W  = 8,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgLoad,
  input  logic              cfgMode,
  input  logic [RD_AW-1:0]  cfgRdStart,
  input  logic [RD_AW-1:0]  cfgRdStep,
  input  logic [CNT_W-1:0]  cfgRdIter,
  input  logic [WR_AW-1:0]  cfgWrStart,
  input  logic [WR_AW-1:0]  cfgWrStep,
  input  logic [CNT_W-1:0]  cfgWrIter,
  input  logic [LAT_W-1:0]  cfgLat,
  output logic [RD_AW-1:0]  bufAddr,
  output logic              bufEn,
  input  logic              bufValid,
  input  logic [DATA_W-1:0] bufData,
  output logic              sramWe,
  output logic [WR_AW-1:0]  sramAddr,
  output logic [DATA_W-1:0] sramWdata,
  output logic              done
);

  step_strb_t strb;
  logic       modeFixed;

  buf_load_ctrl #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfgLoad   (cfgLoad),
    .cfgMode   (cfgMode),
    .cfgRdIter (cfgRdIter),
    .cfgWrIter (cfgWrIter),
    .cfgLat    (cfgLat),
    .bufValid  (bufValid),
    .strb      (strb),
    .bufEn     (bufEn),
    .sramWe    (sramWe),
    .done      (done),
    .modeFixed (modeFixed)
  );

  buf_load_dp #(.DATA_W(DATA_W), .RD_AW(RD_AW), .WR_AW(WR_AW)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .cfgRdStart (cfgRdStart),
    .cfgRdStep  (cfgRdStep),
    .cfgWrStart (cfgWrStart),
    .cfgWrStep  (cfgWrStep),
    .bufData    (bufData),
    .bufAddr    (bufAddr),
    .sramAddr   (sramAddr),
    .sramWdata  (sramWdata)
  );

endmodule

// File: rtl/buf_load_chk.sv
module buf_load_chk #(
  parameter int RD_AW = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             cfgLoad,
  input logic             bufEn,
  input logic [RD_AW-1:0] bufAddr,
  input logic             bufValid,
  input logic             sramWe,
  input logic             done,
  input logic             modeFixed
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !bufEn && !sramWe && !done); // R1

  AST_HS_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    sramWe && !modeFixed |-> bufValid); // R3

  AST_HS_REQUEST_HOLDS: assert property (@(posedge clk) disable iff (rst)
    bufEn && !bufValid && !modeFixed |=> bufEn && $stable(bufAddr)); // R4

  AST_DONE_WHEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> !bufEn && !sramWe); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done && !cfgLoad |=> !done); // R7

endmodule

bind buf_load_seq buf_load_chk #(.RD_AW(RD_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfgLoad   (cfgLoad),
  .bufEn     (bufEn),
  .bufAddr   (bufAddr),
  .bufValid  (bufValid),
  .sramWe    (sramWe),
  .done      (done),
  .modeFixed (modeFixed)
);

// File: tb/sim_buf_load_seq.sv
module sim_buf_load_seq;

  localparam int DATA_W = 32;
  localparam int RD_AW  = 10;
  localparam int WR_AW  = 8;
  localparam int CNT_W  = 8;
  localparam int LAT_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfgLoad = 1'b0;
  logic              cfgMode = 1'b0;
  logic [RD_AW-1:0]  cfgRdStart = '0;
  logic [RD_AW-1:0]  cfgRdStep = '0;
  logic [CNT_W-1:0]  cfgRdIter = '0;
  logic [WR_AW-1:0]  cfgWrStart = '0;
  logic [WR_AW-1:0]  cfgWrStep = '0;
  logic [CNT_W-1:0]  cfgWrIter = '0;
  logic [LAT_W-1:0]  cfgLat = '0;
  logic              bufValid = 1'b0;
  logic [DATA_W-1:0] bufData = '0;
  logic [RD_AW-1:0]  bufAddr;
  logic              bufEn;
  logic              sramWe;
  logic [WR_AW-1:0]  sramAddr;
  logic [DATA_W-1:0] sramWdata;
  logic              done;

  always #10 clk = ~clk;  // 50 MHz

  buf_load_seq #(
    .DATA_W(DATA_W), .RD_AW(RD_AW), .WR_AW(WR_AW), .CNT_W(CNT_W), .LAT_W(LAT_W)
  ) u0 (
    .clk(clk), .rst(rst), .cfgLoad(cfgLoad), .cfgMode(cfgMode),
    .cfgRdStart(cfgRdStart), .cfgRdStep(cfgRdStep), .cfgRdIter(cfgRdIter),
    .cfgWrStart(cfgWrStart), .cfgWrStep(cfgWrStep), .cfgWrIter(cfgWrIter),
    .cfgLat(cfgLat), .bufAddr(bufAddr), .bufEn(bufEn), .bufValid(bufValid),
    .bufData(bufData), .sramWe(sramWe), .sramAddr(sramAddr),
    .sramWdata(sramWdata), .done(done)
  );

  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 1'b0;
  string phase = "R1";

  // behavioural reference: pending address lists per side
  int rdQ[$];
  int wrQ[$];
  bit mFixed = 1'b0;
  int mLat = 0;
  int mTick = 0;
  bit mDone = 1'b0;
  bit armed = 1'b0;

  always @(posedge clk) begin : model
    bit busyBefore, busyAfter, nd;
    if (rst) begin
      rdQ.delete();
      wrQ.delete();
      mDone  = 1'b0;
      mFixed = 1'b0;
      mTick  = 0;
      armed  = 1'b1;
    end else begin
      busyBefore = (rdQ.size() != 0) || (wrQ.size() != 0);
      if (mFixed) begin
        if (rdQ.size() != 0) void'(rdQ.pop_front());
        if (wrQ.size() != 0 && mTick >= mLat) void'(wrQ.pop_front());
        mTick++;
      end else if (bufValid === 1'b1) begin
        if (rdQ.size() != 0) void'(rdQ.pop_front());
        if (wrQ.size() != 0) void'(wrQ.pop_front());
      end
      busyAfter = (rdQ.size() != 0) || (wrQ.size() != 0);
      nd = busyBefore && !busyAfter;
      if (cfgLoad && !busyBefore) begin
        for (int k = 0; k < int'(cfgRdIter); k++)
          rdQ.push_back((int'(cfgRdStart) + k * int'(cfgRdStep)) % (1 << RD_AW));
        for (int k = 0; k < int'(cfgWrIter); k++)
          wrQ.push_back((int'(cfgWrStart) + k * int'(cfgWrStep)) % (1 << WR_AW));
        mFixed = cfgMode;
        mLat   = int'(cfgLat);
        mTick  = 0;
        nd     = (cfgRdIter == '0) && (cfgWrIter == '0);
      end
      mDone = nd;
    end
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (phase %s) %s: actual %0h expected %0h at %0t",
               req, phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin : compare
    bit expEn, expWe;
    #1;
    if (armed) begin
      expEn = (rdQ.size() != 0);
      expWe = (wrQ.size() != 0) && (mFixed ? (mTick >= mLat) : (bufValid === 1'b1));
      check("R4", "bufEn", 64'(bufEn), 64'(expEn));
      if (expEn) check("R2", "bufAddr", 64'(bufAddr), 64'(rdQ[0]));
      check(mFixed ? "R6" : "R3", "sramWe", 64'(sramWe), 64'(expWe));
      if (expWe) begin
        check("R3", "sramAddr", 64'(sramAddr), 64'(wrQ[0]));
        check("R3", "sramWdata", 64'(sramWdata), 64'(bufData));
      end
      check("R7", "done", 64'(done), 64'(mDone));
    end
  end

  task automatic cyc(int n, int dens);
    repeat (n) begin
      @(negedge clk);
      cfgLoad  = 1'b0;
      bufValid = ($urandom % 100) < dens;
      bufData  = $urandom;
    end
  endtask

  task automatic load(int rs, int rstp, int ws, int wstp, int ri, int wi,
                      bit fixed, int lat);
    @(negedge clk);
    cfgRdStart = RD_AW'(rs);
    cfgRdStep  = RD_AW'(rstp);
    cfgWrStart = WR_AW'(ws);
    cfgWrStep  = WR_AW'(wstp);
    cfgRdIter  = CNT_W'(ri);
    cfgWrIter  = CNT_W'(wi);
    cfgMode    = fixed;
    cfgLat     = LAT_W'(lat);
    cfgLoad    = 1'b1;
    bufValid   = 1'b0;
    bufData    = $urandom;
  endtask

  initial begin
    // R1: reset state, then idle with stray valid pulses
    phase = "R1";
    cyc(3, 0);
    @(negedge clk) rst = 1'b0;
    cyc(4, 50);

    // R2/R3: handshake, buffer 0..3 into SRAM 3..6, valid held off first
    phase = "R2";
    load(0, 1, 3, 1, 4, 4, 1'b0, 0);
    cyc(3, 0);
    phase = "R4";
    cyc(20, 40);

    // R5: valid pulses after completion must not write
    phase = "R5";
    cyc(6, 100);

    // R8: second configuration during a transfer is dropped
    phase = "R8";
    load(100, 2, 10, 1, 6, 6, 1'b0, 0);
    cyc(2, 0);
    load(7, 7, 7, 7, 1, 1, 1'b1, 0);
    cyc(30, 50);

    // R6: fixed latency 3, 0 and 1, valid toggling randomly
    phase = "R6";
    load(5, 3, 20, 2, 5, 5, 1'b1, 3);
    cyc(14, 60);
    load(40, 1, 60, 1, 4, 4, 1'b1, 0);
    cyc(8, 30);
    load(9, 4, 0, 5, 3, 3, 1'b1, 1);
    cyc(8, 70);

    // R9: wrap of both address spaces, in both modes
    phase = "R9";
    load(1020, 5, 254, 3, 6, 6, 1'b0, 0);
    cyc(30, 60);
    load(1022, 1, 255, 1, 3, 3, 1'b1, 2);
    cyc(8, 0);

    // R7: unequal counts, both counts zero, write count zero
    phase = "R7";
    load(0, 1, 0, 1, 2, 5, 1'b0, 0);
    cyc(30, 50);
    load(0, 0, 0, 0, 0, 0, 1'b0, 0);
    cyc(3, 0);
    load(12, 1, 0, 0, 3, 0, 1'b1, 0);
    cyc(6, 0);

    // R10: reset in the middle of a transfer
    phase = "R10";
    load(0, 1, 0, 1, 20, 20, 1'b0, 0);
    cyc(5, 70);
    @(negedge clk) rst = 1'b1;
    cyc(2, 50);
    @(negedge clk) rst = 1'b0;
    cyc(6, 60);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired (phase %s)", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule